// File: doc/BRIEF.md
# Coarse Coprocessor Register Trap Filter

This block is a purely combinational filter. For one legacy coprocessor register access, it decides whether coarse-grained hypervisor controls require the access to be diverted to the hypervisor level. The access is described by two 4-bit register numbers: a primary number `crn_i` and a secondary number `crm_i`. A flag `pair_i` tells a single-register transfer from a double-register one.

Two independent rules can raise the trap:

- **Register-mask rule.** A 16-bit mask holds one enable per register index. Two indexes are permanently exempt from this rule, and the whole rule is switched off in host mode.
- **Implementation-defined rule.** A single enable bit selects a fixed table of implementation-defined register groups. This rule applies only to single-register transfers.

Both rules are considered only when hypervisor support is enabled and the requester runs at level 0 or 1. The filter sits beside an instruction decoder. The decoder supplies the register fields. The exception logic consumes `trap_o`.

Top module: `cp_coarse_trap_filter`

## Requirements
- R1: With `l2_en_i` low, `trap_o` is 0 for every other input combination.
- R2: With `level_i` equal to 2 or 3, `trap_o` is 0. Only levels 0 and 1 can produce a trap. Level encoding: 0 = user, 1 = kernel, 2 = hypervisor, 3 = monitor.
- R3: The mask index is `crn_i` when `pair_i`=0 (single register) and `crm_i` when `pair_i`=1 (double register). `trap_o` is 1 when the mask bit at that index is 1, the filter is eligible, and `host_i`=0.
- R4: Mask bits 4 and 14 never cause a trap, whatever their value.
- R5: With `host_i` high, `reg_mask_i` has no effect on `trap_o`.
- R6: With `impl_trap_i`=1 and `pair_i`=0, `crn_i`=9 traps when `crm_i` is one of 0, 1, 2, 5, 6, 7 or 8. Other `crm_i` values do not trap through this rule.
- R7: Under the same conditions, `crn_i`=10 traps when `crm_i` is one of 0, 1, 4 or 8. `crn_i`=11 traps when `crm_i` is 0 through 8 or 15.
- R8: A double-register access (`pair_i`=1) is never trapped by the implementation-defined rule.
- R9: With `impl_trap_i`=0, the implementation-defined table has no effect. The mask rule and the implementation-defined rule are OR-combined, so either one alone is enough to trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| crn_i | input | 4 | Primary register number of the access |
| crm_i | input | 4 | Secondary register number of the access |
| pair_i | input | 1 | 1 = double-register transfer, 0 = single |
| level_i | input | 2 | Current level (0 user, 1 kernel, 2 hypervisor, 3 monitor) |
| l2_en_i | input | 1 | Hypervisor level enabled |
| host_i | input | 1 | Host mode active; disables the mask rule |
| reg_mask_i | input | 16 | Per-index trap enable mask |
| impl_trap_i | input | 1 | Enable for the implementation-defined group table |
| trap_o | output | 1 | Access must be trapped to the hypervisor level |

## Verification
The bench builds the filter with its default parameters. These are a 4-bit register index, hence a 16-entry mask, and the three-group table starting at primary number 9. With these values the exempt indexes and every group boundary lie in the input space the bench drives. The 4-bit inputs allow exhaustive-style coverage of each table row by random draws, alongside directed probes of the table edges (such as secondary numbers 3, 9 and 15). The random stimulus also covers host mode overlapping the implementation-defined rule, where only the second rule can trap.

// File: rtl/ccrt_pkg.sv
package ccrt_pkg;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } level_e;

  // Mask indexes that the per-register rule can never trap.
  localparam int unsigned EXEMPT_LO = 4;
  localparam int unsigned EXEMPT_HI = 14;

  function automatic logic is_low_level(input logic [1:0] lvl);
    return (lvl == LVL_USER) || (lvl == LVL_KERNEL);
  endfunction

  function automatic logic is_exempt(input int unsigned idx);
    return (idx == EXEMPT_LO) || (idx == EXEMPT_HI);
  endfunction

endpackage

// File: rtl/ccrt_gate.sv
module ccrt_gate
  import ccrt_pkg::*;
#(
  parameter int unsigned LVL_W = 2
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic             l2_en_i,
  output logic             eligible_o
);
  logic [1:0] lvl2;
  assign lvl2       = level_i[1:0];
  assign eligible_o = l2_en_i && (LVL_W == 2 ? is_low_level(lvl2) : 1'b0);
endmodule

// File: rtl/ccrt_mask_check.sv
module ccrt_mask_check
  import ccrt_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned NREG = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] crn_i,
  input  logic [IDX_W-1:0] crm_i,
  input  logic             pair_i,
  input  logic             host_i,
  input  logic [NREG-1:0]  reg_mask_i,
  output logic             mask_hit_o
);
  logic [NREG-1:0]  armed;
  logic [IDX_W-1:0] sel_idx;

  for (genvar i = 0; i < NREG; i++) begin : g_arm
    if (is_exempt(i)) begin : g_exempt
      assign armed[i] = 1'b0;
    end else begin : g_live
      assign armed[i] = reg_mask_i[i];
    end
  end

  assign sel_idx    = pair_i ? crm_i : crn_i;
  assign mask_hit_o = !host_i && armed[sel_idx];
endmodule

// File: rtl/ccrt_impl_check.sv
module ccrt_impl_check #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned NGRP     = 3,
  parameter int unsigned GRP_BASE = 9,
  localparam int unsigned NREG    = 1 << IDX_W,
  parameter logic [NGRP*NREG-1:0] GRP_MASKS = {16'h81FF, 16'h0113, 16'h01E7}
) (
  input  logic [IDX_W-1:0] crn_i,
  input  logic [IDX_W-1:0] crm_i,
  input  logic             pair_i,
  input  logic             impl_en_i,
  output logic             impl_hit_o
);
  logic [NGRP-1:0] grp_hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [NREG-1:0]  ROW_MASK = GRP_MASKS[g*NREG +: NREG];
    localparam logic [IDX_W-1:0] ROW_CRN  = IDX_W'(GRP_BASE + g);
    assign grp_hit[g] = (crn_i == ROW_CRN) && ROW_MASK[crm_i];
  end

  assign impl_hit_o = impl_en_i && !pair_i && (|grp_hit);
endmodule

// File: rtl/cp_coarse_trap_filter.sv
module cp_coarse_trap_filter #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned NREG = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] crn_i,
  input  logic [IDX_W-1:0] crm_i,
  input  logic             pair_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             l2_en_i,
  input  logic             host_i,
  input  logic [NREG-1:0]  reg_mask_i,
  input  logic             impl_trap_i,
  output logic             trap_o
);
  logic eligible;
  logic mask_hit;
  logic impl_hit;

  ccrt_gate #(.LVL_W(LVL_W)) u_gate (
    .level_i   (level_i),
    .l2_en_i   (l2_en_i),
    .eligible_o(eligible)
  );

  ccrt_mask_check #(.IDX_W(IDX_W)) u_mask (
    .crn_i     (crn_i),
    .crm_i     (crm_i),
    .pair_i    (pair_i),
    .host_i    (host_i),
    .reg_mask_i(reg_mask_i),
    .mask_hit_o(mask_hit)
  );

  ccrt_impl_check #(.IDX_W(IDX_W)) u_impl (
    .crn_i     (crn_i),
    .crm_i     (crm_i),
    .pair_i    (pair_i),
    .impl_en_i (impl_trap_i),
    .impl_hit_o(impl_hit)
  );

  // Mask rule takes precedence in evaluation order; either hit suffices.
  assign trap_o = eligible && (mask_hit || impl_hit);
endmodule

// File: rtl/cp_coarse_trap_filter_chk.sv
module cp_coarse_trap_filter_chk #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LVL_W = 2
) (
  input logic [IDX_W-1:0] crn_i,
  input logic [IDX_W-1:0] crm_i,
  input logic             pair_i,
  input logic [LVL_W-1:0] level_i,
  input logic             l2_en_i,
  input logic             host_i,
  input logic             impl_trap_i,
  input logic             trap_o,
  input logic             mask_hit,
  input logic             impl_hit
);
  logic [IDX_W-1:0] idx_seen;
  assign idx_seen = pair_i ? crm_i : crn_i;

  always_comb begin
    p_off_when_disabled_r1: assert (l2_en_i || !trap_o)
      else $error("trap raised with hypervisor level disabled");
    p_high_level_quiet_r2: assert (level_i < LVL_W'(2) || !trap_o)
      else $error("trap raised from level 2 or 3");
    p_exempt_index_r4: assert (!mask_hit || (idx_seen != IDX_W'(4) && idx_seen != IDX_W'(14)))
      else $error("mask rule hit on an exempt index");
    p_host_blocks_mask_r5: assert (!host_i || !mask_hit)
      else $error("mask rule hit in host mode");
    p_pair_no_impl_r8: assert (!pair_i || !impl_hit)
      else $error("implementation-defined rule hit on a pair access");
    p_impl_disabled_r9: assert (impl_trap_i || !impl_hit)
      else $error("implementation-defined rule hit while disabled");
  end
endmodule

bind cp_coarse_trap_filter cp_coarse_trap_filter_chk #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_chk (
  .crn_i      (crn_i),
  .crm_i      (crm_i),
  .pair_i     (pair_i),
  .level_i    (level_i),
  .l2_en_i    (l2_en_i),
  .host_i     (host_i),
  .impl_trap_i(impl_trap_i),
  .trap_o     (trap_o),
  .mask_hit   (mask_hit),
  .impl_hit   (impl_hit)
);

// File: tb/test_cp_coarse_trap_filter.sv
module test_cp_coarse_trap_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  crn = '0, crm = '0;
  logic        pair = 1'b0, l2 = 1'b0, host = 1'b0, impl = 1'b0;
  logic [1:0]  lvl = '0;
  logic [15:0] mask = '0;
  logic        trap;
  int          n_checks = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  cp_coarse_trap_filter i_cp_coarse_trap_filter (
    .crn_i(crn), .crm_i(crm), .pair_i(pair), .level_i(lvl), .l2_en_i(l2),
    .host_i(host), .reg_mask_i(mask), .impl_trap_i(impl), .trap_o(trap)
  );

  function automatic bit model(bit [3:0] rn, bit [3:0] rm, bit pr, bit [1:0] lv,
                               bit en, bit hs, bit [15:0] mk, bit im);
    int k;
    bit tbl;
    if (!en) return 1'b0;
    if (lv > 2'd1) return 1'b0;
    k = pr ? int'(rm) : int'(rn);
    if (!hs && k != 4 && k != 14 && mk[k]) return 1'b1;
    if (!im || pr) return 1'b0;
    tbl = 1'b0;
    case (rn)
      4'd9:  tbl = rm inside {4'd0, 4'd1, 4'd2, 4'd5, 4'd6, 4'd7, 4'd8};
      4'd10: tbl = rm inside {4'd0, 4'd1, 4'd4, 4'd8};
      4'd11: tbl = (rm <= 4'd8) || (rm == 4'd15);
      default: tbl = 1'b0;
    endcase
    return tbl;
  endfunction

  task automatic probe(string req, bit [3:0] rn, bit [3:0] rm, bit pr, bit [1:0] lv,
                       bit en, bit hs, bit [15:0] mk, bit im);
    bit want;
    @(negedge clk);
    crn = rn; crm = rm; pair = pr; lvl = lv; l2 = en; host = hs; mask = mk; impl = im;
    #1;
    want = model(rn, rm, pr, lv, en, hs, mk, im);
    n_checks++;
    if (trap !== want) begin
      n_fail++;
      $display("FAIL %s: crn=%0d crm=%0d pair=%0b lvl=%0d trap actual=%0b expected=%0b",
               req, rn, rm, pr, lv, trap, want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0c0ffee5));
    repeat (3) @(posedge clk);
    #1;
    n_checks++;  // R1 reset state: all controls idle
    if (trap !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset state trap actual=%0b expected=0", trap);
    end
    rst_n = 1'b1;

    probe("R1", 4'd3, 4'd0, 0, 2'd0, 0, 0, 16'hFFFF, 1);
    probe("R1", 4'd9, 4'd0, 0, 2'd1, 0, 0, 16'h0000, 1);
    probe("R2", 4'd3, 4'd0, 0, 2'd2, 1, 0, 16'hFFFF, 1);
    probe("R2", 4'd9, 4'd1, 0, 2'd3, 1, 0, 16'hFFFF, 1);
    probe("R3", 4'd3, 4'd0, 0, 2'd0, 1, 0, 16'h0008, 0);
    probe("R3", 4'd3, 4'd7, 1, 2'd1, 1, 0, 16'h0080, 0);
    probe("R3", 4'd3, 4'd7, 1, 2'd1, 1, 0, 16'h0008, 0);
    probe("R4", 4'd4, 4'd0, 0, 2'd0, 1, 0, 16'hFFFF, 0);
    probe("R4", 4'd14, 4'd0, 0, 2'd1, 1, 0, 16'hFFFF, 0);
    probe("R4", 4'd2, 4'd14, 1, 2'd0, 1, 0, 16'hFFFF, 0);
    probe("R5", 4'd5, 4'd0, 0, 2'd0, 1, 1, 16'hFFFF, 0);
    probe("R5", 4'd5, 4'd6, 1, 2'd1, 1, 1, 16'hFFFF, 0);
    probe("R6", 4'd9, 4'd2, 0, 2'd0, 1, 0, 16'h0000, 1);
    probe("R6", 4'd9, 4'd3, 0, 2'd0, 1, 0, 16'h0000, 1);
    probe("R6", 4'd9, 4'd8, 0, 2'd1, 1, 0, 16'h0000, 1);
    probe("R7", 4'd10, 4'd4, 0, 2'd0, 1, 0, 16'h0000, 1);
    probe("R7", 4'd10, 4'd2, 0, 2'd0, 1, 0, 16'h0000, 1);
    probe("R7", 4'd11, 4'd15, 0, 2'd1, 1, 0, 16'h0000, 1);
    probe("R7", 4'd11, 4'd9, 0, 2'd1, 1, 0, 16'h0000, 1);
    probe("R8", 4'd9, 4'd0, 1, 2'd0, 1, 0, 16'h0000, 1);
    probe("R8", 4'd11, 4'd15, 1, 2'd1, 1, 0, 16'h0000, 1);
    probe("R9", 4'd9, 4'd0, 0, 2'd0, 1, 0, 16'h0000, 0);
    probe("R9", 4'd9, 4'd0, 0, 2'd0, 1, 1, 16'hFFFF, 1);
    probe("R9", 4'd9, 4'd3, 0, 2'd1, 1, 0, 16'h0200, 0);

    for (int n = 0; n < 3000; n++) begin
      probe("R9", 4'($urandom), 4'($urandom), 1'($urandom), 2'($urandom),
            ($urandom % 8) != 0, ($urandom % 4) == 0, 16'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule